// File: doc/BRIEF.md
# Prescaled Modulo-255 PWM Generator

This block produces a pulse-width-modulated level from a free-running counter that steps through 2^CNT_W-1 states (0 to 254 at the default width of 8) and then returns to zero. A programmable divider sits in front of the counter. It advances the counter once for every (1+P) clock-enable pulses, where P is the prescaler value. The clock-enable input is expected at half the oscillator rate. The output level rises when the counter reaches the compare value and falls when the counter returns to zero. This gives a low:high ratio of C:(255-C). A compare of zero keeps the level high, and a compare of all ones keeps it low.

A small register write port loads the prescaler, the compare value and the output-enable bit, and clears the period flag. New prescaler and compare values are held in staging registers and copied into use only at the wrap, so a period is never torn. The counter and the period flag keep running while the pin is released to general-purpose use. The block can therefore act as an interval timer. Idle and power-down freeze the divider and the counter, and force the output high.

Top module: `pwm_mod_gen`

## Requirements
- R1: The counter advances once per (1+P) clock-enable pulses, where P is the prescaler register at address 0. A full period takes (2^CNT_W-1)·(1+P) pulses.
- R2: The counter takes the values 0 to 2^CNT_W-2 and wraps from 2^CNT_W-2 back to 0.
- R3: The output level is low from count 0 until the count equals the compare value C (register address 1), and high from that count until the wrap. This gives C low steps and (2^CNT_W-1-C) high steps per period.
- R4: With C = 0 the output is high for the whole period, because set takes precedence over the clear at zero. With C = all ones the output is low for the whole period.
- R5: A write to the prescaler or the compare register during a period leaves that period unchanged. The new value applies from the next wrap.
- R6: Each wrap sets the period flag, which drives ovf_irq. A write of bit 0 = 1 to address 3 clears the flag, and a write of bit 0 = 0 leaves it set. If a wrap and a clear fall in the same cycle, the flag stays set.
- R7: While idle or pdown is high, pwm_out is 1.
- R8: While idle or pdown is high, the counter and the divider hold their state. They resume from that state afterwards, which lengthens the period by the frozen pulses.
- R9: pwm_oe follows bit 0 of the control register at address 2 from the cycle after the write. When the bit is 0, the counter and the period flag keep running.
- R10: Without a clock-enable pulse, neither the divider nor the counter moves.
- R11: After reset, pwm_out is 0, pwm_oe is 0 and ovf_irq is 0. The prescaler is 0, the compare is all ones and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock-enable pulse at half the oscillator rate |
| idle | input | 1 | Idle: freeze the count, force the output high |
| pdown | input | 1 | Power-down: freeze the count, force the output high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 prescaler, 1 compare, 2 control, 3 flag clear |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 1 | PWM level |
| pwm_oe | output | 1 | Pad drive enable |
| ovf_irq | output | 1 | Period flag, set at each wrap |

## Verification
The hardest case to produce from the ports is a flag-clear write landing in the same cycle as a wrap. The bench first aligns to a period by clearing the flag and waiting for it to rise again. With the prescaler at zero it then counts exactly 2^CNT_W-2 cycles and issues the clear on the last count. Staged updates are reached in a similar way: writes are placed at fixed offsets inside a period whose start is known. Idle and power-down windows are placed mid-period, and the bench predicts the stretched wrap time from its own count of the pulses that were not frozen.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;
   // register select codes on the write port
   localparam int unsigned REG_PRESCALE = 0;
   localparam int unsigned REG_COMPARE  = 1;
   localparam int unsigned REG_CONTROL  = 2;
   localparam int unsigned REG_FLAGCLR  = 3;
endpackage

// File: rtl/pwm_mod_regs.sv
module pwm_mod_regs
   import pwm_mod_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 8,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wrap,
   output logic [PRE_W-1:0]  pre_act,
   output logic [CNT_W-1:0]  cmp_act,
   output logic [CNT_W-1:0]  cmp_next,
   output logic              out_en,
   output logic              ovf_flag
);
   localparam logic [CNT_W-1:0] CMP_OFF = '1;

   logic [PRE_W-1:0] pre_stage;
   logic [CNT_W-1:0] cmp_stage;
   logic             sel_pre, sel_cmp, sel_ctl, sel_clr;

   always_comb begin
      sel_pre = wr_en && (wr_addr == ADDR_W'(REG_PRESCALE));
      sel_cmp = wr_en && (wr_addr == ADDR_W'(REG_COMPARE));
      sel_ctl = wr_en && (wr_addr == ADDR_W'(REG_CONTROL));
      sel_clr = wr_en && (wr_addr == ADDR_W'(REG_FLAGCLR));
   end

   // compare value that is in use after the coming edge
   assign cmp_next = wrap ? cmp_stage : cmp_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_stage <= '0;
         pre_act   <= '0;
         cmp_stage <= CMP_OFF;
         cmp_act   <= CMP_OFF;
         out_en    <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         if (sel_pre) pre_stage <= wr_data[PRE_W-1:0];
         if (sel_cmp) cmp_stage <= wr_data[CNT_W-1:0];
         if (sel_ctl) out_en    <= wr_data[0];
         if (wrap) begin
            pre_act <= pre_stage;
            cmp_act <= cmp_stage;
         end
         if (wrap)                     ovf_flag <= 1'b1;
         else if (sel_clr && wr_data[0]) ovf_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_mod_prescale.sv
module pwm_mod_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PRE_W-1:0] pre_act,
   output logic             step
);
   logic [PRE_W-1:0] pcnt;

   assign step = tick && (pcnt == pre_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pcnt <= '0;
      else if (step) pcnt <= '0;
      else if (tick) pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/pwm_mod_count.sv
module pwm_mod_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap
);
   localparam int unsigned    LAST  = (2 ** CNT_W) - 2;
   localparam logic [CNT_W-1:0] CLAST = CNT_W'(LAST);

   assign wrap    = step && (cnt == CLAST);
   assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt_nxt;
   end
endmodule

// File: rtl/pwm_mod_wave.sv
module pwm_mod_wave #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cmp_next,
   input  logic             force_hi,
   input  logic             out_en,
   output logic             lvl,
   output logic             pwm_out,
   output logic             pwm_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl <= 1'b0;
      else if (step) begin
         // match sets, zero clears; set wins when both apply
         if (cnt_nxt == cmp_next) lvl <= 1'b1;
         else if (cnt_nxt == '0)  lvl <= 1'b0;
      end
   end

   assign pwm_out = force_hi | lvl;
   assign pwm_oe  = out_en;
endmodule

// File: rtl/pwm_mod_gen.sv
module pwm_mod_gen #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 8,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              idle,
   input  logic              pdown,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_out,
   output logic              pwm_oe,
   output logic              ovf_irq
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_mod_gen: CNT_W must lie in 2..DATA_W");
   end
   if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
      $error("pwm_mod_gen: PRE_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pwm_mod_gen: ADDR_W must be at least 2");
   end

   logic             force_hi, tick, step, wrap, lvl, out_en;
   logic [PRE_W-1:0] pre_act;
   logic [CNT_W-1:0] cnt, cnt_nxt, cmp_act, cmp_next;

   assign force_hi = idle | pdown;
   assign tick     = clk_en & ~force_hi;

   pwm_mod_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wrap(wrap), .pre_act(pre_act), .cmp_act(cmp_act), .cmp_next(cmp_next),
      .out_en(out_en), .ovf_flag(ovf_irq)
   );

   pwm_mod_prescale #(.PRE_W(PRE_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pre_act(pre_act), .step(step)
   );

   pwm_mod_count #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
   );

   pwm_mod_wave #(.CNT_W(CNT_W)) wave_i (
      .clk(clk), .rst_n(rst_n), .step(step), .cnt_nxt(cnt_nxt), .cmp_next(cmp_next),
      .force_hi(force_hi), .out_en(out_en), .lvl(lvl), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );
endmodule

// File: rtl/pwm_mod_chk.sv
module pwm_mod_chk #(
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en,
   input logic              idle,
   input logic              pdown,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_bit0,
   input logic              wrap,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp_act,
   input logic              lvl,
   input logic              pwm_out,
   input logic              pwm_oe,
   input logic              ovf_irq
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'((2 ** CNT_W) - 2);
   localparam logic [CNT_W-1:0] OFF  = '1;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST); // R2
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> (cnt == '0)); // R2
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> ovf_irq); // R6
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(3) && wr_bit0 && !wrap) |=> !ovf_irq); // R6
   AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (idle || pdown) |-> pwm_out); // R7
   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (idle || pdown) |=> (cnt == $past(cnt))); // R8
   AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> (cnt == $past(cnt))); // R10
   AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cmp_act == '0) |-> lvl); // R4
   AST_CMP_OFF: assert property (@(posedge clk) disable iff (!rst_n) (cmp_act == OFF) |-> !lvl); // R4
   AST_OE_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(2)) |=> (pwm_oe == $past(wr_bit0))); // R9
endmodule

bind pwm_mod_gen pwm_mod_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .idle(idle), .pdown(pdown),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .wrap(wrap),
   .cnt(cnt), .cmp_act(cmp_act), .lvl(lvl), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
   .ovf_irq(ovf_irq)
);

// File: tb/pwm_mod_gen_tb.sv
`timescale 1ns/1ps
module pwm_mod_gen_tb_top;
   localparam int CW  = 4;
   localparam int PW  = 3;
   localparam int MOD = (1 << CW) - 1;

   logic       clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, idle = 1'b0, pdown = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out, pwm_oe, ovf_irq;
   int         checks = 0, fails = 0;
   bit         ce_half = 1'b0;

   always #2.5 clk = ~clk;

   pwm_mod_gen #(.DATA_W(8), .ADDR_W(2), .CNT_W(CW), .PRE_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .idle(idle), .pdown(pdown),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe), .ovf_irq(ovf_irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // clear the flag, then stop at the first cycle of a fresh period
   task automatic wait_wrap();
      wr(3, 1);
      while (!ovf_irq) @(negedge clk);
   endtask

   // one period starting at count 0; checks the level every cycle and the wrap time
   task automatic run_period(input int c, input int p, input int hold_from, input int hold_len,
                             input bit use_pd, input int wa, input int wadr, input int wd,
                             input string req);
      int j = 0, act = 0, bad = 0, flagbad = 0;
      bit hold, tk, expv;
      forever begin
         hold   = (j >= hold_from) && (j < hold_from + hold_len);
         tk     = ce_half ? (j % 2 == 0) : 1'b1;
         idle   = hold && !use_pd;
         pdown  = hold && use_pd;
         clk_en = tk;
         wr_en  = (j == 0) || (j == wa);
         wr_addr = (j == 0) ? 2'd3 : 2'(wadr);
         wr_data = (j == 0) ? 8'd1 : 8'(wd);
         #1;
         expv = hold ? 1'b1 : ((c < MOD) && ((act / (p + 1)) >= c));
         if (pwm_out !== expv) bad++;
         if (j > 0 && ovf_irq) flagbad++;
         if (!hold && tk) act++;
         @(negedge clk);
         j++;
         if (act == MOD * (p + 1)) break;
      end
      idle = 1'b0; pdown = 1'b0; clk_en = 1'b1; wr_en = 1'b0;
      check(bad == 0, req, $sformatf("level mismatches c=%0d p=%0d", c, p), bad, 0);
      check(ovf_irq && flagbad == 0, req, $sformatf("wrap after %0d cycles, early flags", j),
            flagbad + (ovf_irq ? 0 : 1000), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      check(pwm_out == 1'b0, "R11", "pwm_out after reset", pwm_out, 0);
      check(ovf_irq == 1'b0, "R11", "ovf_irq after reset", ovf_irq, 0);
      check(pwm_oe == 1'b0, "R9", "pwm_oe after reset", pwm_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 / R4: disabled output, reset compare all ones, counter still wraps
      wait_wrap();
      run_period(MOD, 0, -1, 0, 1'b0, -1, 0, 0, "R9");
      check(pwm_oe == 1'b0, "R9", "pwm_oe while disabled", pwm_oe, 0);
      wr(2, 1);
      check(pwm_oe == 1'b1, "R9", "pwm_oe after enable", pwm_oe, 1);

      // R3 / R4: every compare value, prescaler 0
      for (int c = 0; c <= MOD; c++) begin
         wr(1, c);
         wait_wrap();
         run_period(c, 0, -1, 0, 1'b0, -1, 0, 0, (c == 0 || c == MOD) ? "R4" : "R3");
      end

      // R1: every prescaler value
      for (int p = 0; p < (1 << PW); p++) begin
         wr(0, p);
         wr(1, 6);
         wait_wrap();
         run_period(6, p, -1, 0, 1'b0, -1, 0, 0, "R1");
      end

      // R5: staged compare and prescaler updates
      wr(0, 0);
      wr(1, 3);
      wait_wrap();
      run_period(3, 0, -1, 0, 1'b0, 5, 1, 10, "R5");
      run_period(10, 0, -1, 0, 1'b0, 4, 0, 2, "R5");
      run_period(10, 2, -1, 0, 1'b0, -1, 0, 0, "R5");

      // R8 / R7: idle and power-down windows inside a period
      run_period(10, 2, 7, 20, 1'b0, -1, 0, 0, "R8");
      run_period(10, 2, 3, 9, 1'b1, -1, 0, 0, "R7");

      // R10: clock enable on alternate cycles
      ce_half = 1'b1;
      run_period(10, 2, -1, 0, 1'b0, -1, 0, 0, "R10");
      ce_half = 1'b0;

      // R6: flag clear, clear with bit0=0, clear colliding with wrap
      run_period(10, 2, -1, 0, 1'b0, 2, 0, 0, "R2");
      wr(3, 1);                        // now at count 1
      check(ovf_irq == 1'b0, "R6", "flag after clear", ovf_irq, 0);
      repeat (MOD - 2) @(negedge clk); // now at last count
      wr(3, 1);                        // clear and wrap in the same edge
      check(ovf_irq == 1'b1, "R6", "set wins over clear", ovf_irq, 1);
      wr(3, 0);
      check(ovf_irq == 1'b1, "R6", "clear with bit0=0 ignored", ovf_irq, 1);
      wr(3, 1);
      check(ovf_irq == 1'b0, "R6", "flag after second clear", ovf_irq, 0);

      wr(2, 0);
      check(pwm_oe == 1'b0, "R9", "pwm_oe after disable", pwm_oe, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule